// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces the processor reset for a chip domain from two digital sources: a "supply below threshold" flag from an external comparator and an active-low manual reset request, such as a push button or another block's reset output. Reset stays asserted while either source is active. After both sources have cleared, reset stays asserted for a fixed hold period. Each new supply dip or manual press during an active reset starts the hold period over. Because of this, a bouncing button needs no debounce logic of its own.

The hold period is set by the parameter `HOLD_TICKS` and is counted in cycles where the free-running `tick_en_i` is high. With a 1 kHz tick, the default of 200 gives a hold of about 200 ms; a simulation can set it much smaller. Both source inputs pass through a two-flop synchronizer. The parameter `POLARITY` selects the outputs: active-high only, active-low only, or both as a complementary pair. An output that is not selected sits at its inactive level. A two-bit cause code tells a supply-low reset apart from a manual reset and from the hold period that follows either one.

Top module: `supsv_reset_gen`

## Requirements
- R1: While `rst` is high, and on the first sample after `rst` falls, reset is asserted and `cause_o` reads 2'b01 (supply low), whatever the level of the inputs.
- R2: When `supply_low_i` is driven high, reset is asserted after the third rising clock edge and not before it. Reset stays asserted while the flag stays high.
- R3: Let edge J be the second rising edge after the last active source is removed. Reset then stays asserted through HOLD_TICKS further edges that have `tick_en_i` high, and it deasserts on the last of those edges.
- R4: If a source becomes active again while the hold period is running, the count is cleared. A full new hold period then follows its next release.
- R5: Driving `manual_n_i` low asserts reset with the same three-edge latency as R2. The same hold period as R3 follows its release.
- R6: A low pulse on `manual_n_i` that arrives while the hold period is running, and before the period expires, keeps reset asserted without a gap and restarts the hold.
- R7: The hold counter advances only on edges where `tick_en_i` is high. With `tick_en_i` held low, reset stays asserted indefinitely once the sources have cleared.
- R8: POLARITY selects the outputs. With POL_HIGH, `reset_o` carries the reset and `reset_n_o` stays 1. With POL_LOW, `reset_n_o` carries it inverted and `reset_o` stays 0. With POL_BOTH, both outputs are driven as a complementary pair.
- R9: `cause_o` encodes the reason for reset as follows: 2'b00 means idle (no reset), 2'b01 means supply low, 2'b10 means manual request, and 2'b11 means the hold period is running. When both sources are active, supply low takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tick_en_i | input | 1 | Timebase tick; each high cycle advances the hold count |
| supply_low_i | input | 1 | Asynchronous supply-below-threshold flag, active high |
| manual_n_i | input | 1 | Asynchronous manual reset request, active low |
| reset_o | output | 1 | Active-high reset (held at 0 when POLARITY is POL_LOW) |
| reset_n_o | output | 1 | Active-low reset (held at 1 when POLARITY is POL_HIGH) |
| cause_o | output | 2 | Reset cause: 00 idle, 01 supply, 10 manual, 11 hold |

## Verification
The supply-low source and the manual source can be active in the same cycle. The bench drives both together and checks that `cause_o` reports the supply as the cause. It then drops the supply while the manual request stays low and checks that the cause moves to manual with no gap in reset. It also releases both sources in the same cycle and checks that exactly one hold period follows, with deassertion on the predicted edge. Two separate collisions are checked the same way: a manual bounce that lands one edge before the hold would expire, and a supply dip that arrives late in the hold. In both cases the bench confirms that reset never drops and that the full period restarts.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

    typedef enum logic [1:0] {
        POL_HIGH = 2'd0,
        POL_LOW  = 2'd1,
        POL_BOTH = 2'd2
    } pol_mode_t;

    typedef enum logic [1:0] {
        CAUSE_IDLE   = 2'b00,
        CAUSE_SUPPLY = 2'b01,
        CAUSE_MANUAL = 2'b10,
        CAUSE_HOLD   = 2'b11
    } cause_t;

    // synchronized, active-high reset sources
    typedef struct packed {
        logic supply_low;
        logic manual;
    } src_t;

    // supply low wins over a manual request
    function automatic cause_t pick_cause(input src_t s);
        if (s.supply_low)  return CAUSE_SUPPLY;
        else if (s.manual) return CAUSE_MANUAL;
        else               return CAUSE_IDLE;
    endfunction

endpackage

// File: rtl/supsv_sync.sv
module supsv_sync #(
    parameter int                WIDTH   = 2,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/supsv_hold.sv
module supsv_hold
    import supsv_pkg::*;
#(
    parameter int HOLD_TICKS = 200
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en_i,
    input  src_t   src_i,
    output logic   busy_o,
    output cause_t cause_o
);
    localparam int           CW   = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    cause_t        cause_q;
    logic          any_src;

    assign any_src = src_i.supply_low | src_i.manual;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            cause_q <= CAUSE_SUPPLY;
        end else if (any_src) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            cause_q <= pick_cause(src_i);
        end else if (busy_q && tick_en_i) begin
            if (cnt_q == LAST) begin
                busy_q  <= 1'b0;
                cnt_q   <= '0;
                cause_q <= CAUSE_IDLE;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                cause_q <= CAUSE_HOLD;
            end
        end else if (busy_q) begin
            cause_q <= CAUSE_HOLD;
        end
    end

    assign busy_o  = busy_q;
    assign cause_o = cause_q;

    // R1: reset state is asserted with cause supply-low
    p_powerup_asserted_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy_q && cause_q == CAUSE_SUPPLY));

    // R2 / R5: an active source forces reset on the next edge
    p_src_forces_reset_r2: assert property (@(posedge clk) disable iff (rst)
        any_src |=> busy_q);

    // R4: an active source clears the hold count
    p_hold_restart_r4: assert property (@(posedge clk) disable iff (rst)
        any_src |=> (cnt_q == '0));

    // R3: reset only falls after the last tick of a full count
    p_release_after_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(cnt_q) == LAST && $past(tick_en_i) && !$past(any_src)));

    // R3: count never passes its limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: without a tick the count and reset hold still
    p_no_tick_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !any_src && !tick_en_i) |=> ($stable(cnt_q) && busy_q));

    // R9: supply low has priority in the cause code
    p_supply_wins_r9: assert property (@(posedge clk) disable iff (rst)
        src_i.supply_low |=> (cause_q == CAUSE_SUPPLY));
endmodule

// File: rtl/supsv_out.sv
module supsv_out
    import supsv_pkg::*;
#(
    parameter pol_mode_t MODE = POL_BOTH
) (
    input  logic active_i,
    output logic reset_o,
    output logic reset_n_o
);
    generate
        if (MODE == POL_HIGH) begin : g_high
            assign reset_o   = active_i;
            assign reset_n_o = 1'b1;
        end else if (MODE == POL_LOW) begin : g_low
            assign reset_o   = 1'b0;
            assign reset_n_o = ~active_i;
        end else begin : g_both
            assign reset_o   = active_i;
            assign reset_n_o = ~active_i;
        end
    endgenerate
endmodule

// File: rtl/supsv_reset_gen.sv
module supsv_reset_gen
    import supsv_pkg::*;
#(
    parameter int        HOLD_TICKS = 200,     // 200 ms with a 1 kHz tick
    parameter int        SYNC_STAGES = 2,
    parameter pol_mode_t POLARITY   = POL_BOTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en_i,
    input  logic       supply_low_i,
    input  logic       manual_n_i,
    output logic       reset_o,
    output logic       reset_n_o,
    output logic [1:0] cause_o
);
    logic [1:0] raw_q;
    src_t       src;
    logic       busy;
    cause_t     cause;

    // bit 1: supply low (reset value: low), bit 0: manual_n (reset value: released)
    supsv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({supply_low_i, manual_n_i}),
        .q_o (raw_q)
    );

    assign src.supply_low = raw_q[1];
    assign src.manual     = ~raw_q[0];

    supsv_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .tick_en_i (tick_en_i),
        .src_i     (src),
        .busy_o    (busy),
        .cause_o   (cause)
    );

    supsv_out #(.MODE(POLARITY)) u_out (
        .active_i  (busy),
        .reset_o   (reset_o),
        .reset_n_o (reset_n_o)
    );

    assign cause_o = cause;

    // R9: a non-idle cause appears exactly when reset is active
    generate
        if (POLARITY == POL_LOW) begin : g_chk_low
            p_cause_tracks_r9: assert property (@(posedge clk) disable iff (rst)
                (cause_o != CAUSE_IDLE) == !reset_n_o);
            p_pol_low_r8: assert property (@(posedge clk) disable iff (rst)
                !reset_o);
        end else begin : g_chk_high
            p_cause_tracks_r9: assert property (@(posedge clk) disable iff (rst)
                (cause_o != CAUSE_IDLE) == reset_o);
            if (POLARITY == POL_HIGH) begin : g_h
                p_pol_high_r8: assert property (@(posedge clk) disable iff (rst)
                    reset_n_o);
            end else begin : g_b
                p_pol_both_r8: assert property (@(posedge clk) disable iff (rst)
                    reset_o != reset_n_o);
            end
        end
    endgenerate
endmodule

// File: tb/supsv_reset_gen_tb.sv
module supsv_reset_gen_tb_top;
    import supsv_pkg::*;

    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic sup_low = 1'b1;
    logic man_n = 1'b1;

    logic       rb_o, rb_n;
    logic [1:0] rb_cause;
    logic       rh_o, rh_n;
    logic [1:0] rh_cause;
    logic       rl_o, rl_n;
    logic [1:0] rl_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    supsv_reset_gen #(.HOLD_TICKS(HOLD), .POLARITY(POL_BOTH)) dut_i (
        .clk(clk), .rst(rst), .tick_en_i(tick_en), .supply_low_i(sup_low),
        .manual_n_i(man_n), .reset_o(rb_o), .reset_n_o(rb_n), .cause_o(rb_cause));

    supsv_reset_gen #(.HOLD_TICKS(HOLD), .POLARITY(POL_HIGH)) dut_hi (
        .clk(clk), .rst(rst), .tick_en_i(tick_en), .supply_low_i(sup_low),
        .manual_n_i(man_n), .reset_o(rh_o), .reset_n_o(rh_n), .cause_o(rh_cause));

    supsv_reset_gen #(.HOLD_TICKS(HOLD), .POLARITY(POL_LOW)) dut_lo (
        .clk(clk), .rst(rst), .tick_en_i(tick_en), .supply_low_i(sup_low),
        .manual_n_i(man_n), .reset_o(rl_o), .reset_n_o(rl_n), .cause_o(rl_cause));

    typedef struct packed {
        logic       sup;
        logic       mrn;
        logic       tick;
        logic [7:0] n;
        logic       exp_rst;
        logic [1:0] exp_cause;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 8'd3,  1'b1, 2'b01, 8'd2},  // R2 supply low held
        '{1'b0, 1'b1, 1'b1, 8'd2,  1'b1, 2'b01, 8'd3},  // R3 release in sync
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b1, 2'b11, 8'd3},  // R3 hold starts
        '{1'b0, 1'b1, 1'b1, 8'd4,  1'b1, 2'b11, 8'd3},  // R3 last held edge
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 2'b00, 8'd3},  // R3 release edge
        '{1'b0, 1'b1, 1'b1, 8'd5,  1'b0, 2'b00, 8'd3},  // R3 idle
        '{1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 2'b00, 8'd5},  // R5 still in sync
        '{1'b0, 1'b0, 1'b1, 8'd1,  1'b1, 2'b10, 8'd5},  // R5 manual asserts
        '{1'b0, 1'b1, 1'b1, 8'd2,  1'b1, 2'b10, 8'd5},  // R5 release in sync
        '{1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 2'b11, 8'd5},  // R5 hold
        '{1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 2'b10, 8'd6},  // R6 bounce at expiry
        '{1'b0, 1'b1, 1'b1, 8'd2,  1'b1, 2'b10, 8'd6},  // R6
        '{1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 2'b11, 8'd6},  // R6 full restart
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 2'b00, 8'd6},  // R6 release
        '{1'b1, 1'b1, 1'b0, 8'd3,  1'b1, 2'b01, 8'd7},  // R7 no tick
        '{1'b0, 1'b1, 1'b0, 8'd20, 1'b1, 2'b11, 8'd7},  // R7 stalled hold
        '{1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 2'b11, 8'd7},  // R7 ticks resume
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 2'b00, 8'd7},  // R7 release
        '{1'b1, 1'b1, 1'b1, 8'd3,  1'b1, 2'b01, 8'd4},  // R4
        '{1'b0, 1'b1, 1'b1, 8'd5,  1'b1, 2'b11, 8'd4},  // R4 mid hold
        '{1'b1, 1'b1, 1'b1, 8'd3,  1'b1, 2'b01, 8'd4},  // R4 dip late in hold
        '{1'b0, 1'b1, 1'b1, 8'd7,  1'b1, 2'b11, 8'd4},  // R4 full hold again
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 2'b00, 8'd4},  // R4 release
        '{1'b1, 1'b0, 1'b1, 8'd3,  1'b1, 2'b01, 8'd9},  // R9 supply wins
        '{1'b0, 1'b0, 1'b1, 8'd3,  1'b1, 2'b10, 8'd9},  // R9 manual remains
        '{1'b0, 1'b1, 1'b1, 8'd7,  1'b1, 2'b11, 8'd9},  // R9 hold
        '{1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 2'b00, 8'd9},  // R9 idle
        '{1'b1, 1'b0, 1'b1, 8'd3,  1'b1, 2'b01, 8'd9},  // R9 both active
        '{1'b0, 1'b1, 1'b1, 8'd8,  1'b0, 2'b00, 8'd3}   // R3 joint release, one hold
    };

    // compares all three instances against one expected reset level (R8 polarity)
    task automatic check_all(input logic exp_rst, input logic [1:0] exp_cause, input int req);
        logic ok;
        ok = (rb_o === exp_rst) && (rb_n === !exp_rst) && (rb_cause === exp_cause) &&
             (rh_o === exp_rst) && (rh_n === 1'b1) && (rh_cause === exp_cause) &&
             (rl_o === 1'b0) && (rl_n === !exp_rst) && (rl_cause === exp_cause);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d (R8 polarity set): both=%b/%b/%b high=%b/%b/%b low=%b/%b/%b expected reset=%b cause=%b",
                     req, rb_o, rb_n, rb_cause, rh_o, rh_n, rh_cause, rl_o, rl_n, rl_cause,
                     exp_rst, exp_cause);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all(1'b1, 2'b01, 1);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all(1'b1, 2'b01, 1);   // R1 first sample after reset

        for (int v = 0; v < NV; v++) begin
            sup_low = VECS[v].sup;
            man_n   = VECS[v].mrn;
            tick_en = VECS[v].tick;
            repeat (int'(VECS[v].n)) @(posedge clk);
            @(negedge clk);
            check_all(VECS[v].exp_rst, VECS[v].exp_cause, int'(VECS[v].req));
        end

        // R1: reset applied while idle, with the supply good
        sup_low = 1'b0;
        man_n   = 1'b1;
        tick_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all(1'b0, 2'b00, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all(1'b1, 2'b01, 1);
        rst = 1'b0;
        // R3: synchronizers reset to supply-low, so one hold follows
        repeat (7) @(posedge clk);
        @(negedge clk);
        check_all(1'b1, 2'b11, 3);
        @(posedge clk);
        @(negedge clk);
        check_all(1'b0, 2'b00, 3);

        // R2: a single-cycle supply pulse still gives a full reset
        sup_low = 1'b1;
        @(negedge clk);
        sup_low = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all(1'b1, 2'b01, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule